// File: doc/BRIEF.md
# Fractional BITS Clock Synthesizer

This block derives a 1.544 MHz or 2.048 MHz BITS clock straight from the system clock. It needs no second oscillator. A divide by a fixed integer cannot produce either rate from the permitted system clocks, so the block uses a fractional accumulator. On each system clock the accumulator adds the BITS-cycles-per-frame count, modulo the system-clocks-per-frame count. Each wrap of the accumulator begins a new BITS period. Periods therefore come in two adjacent integer lengths, and each 8 kHz frame holds exactly the right number of BITS cycles.

The 8 kHz frame-start strobe resets the accumulator and the output phase. The first rising edge of the BITS clock in every frame therefore coincides with the frame edge. The rate select and the system-clock code are captured only on that strobe, so a frame is never built with mixed settings. A control/mode word presents the rate select pin at bit 2 so that software can read it.

Top module: `bits_clk_synth`

## Requirements
- R1: A frame of full length holds exactly 193 rising edges on `bits_clk_o` when the captured rate select is 1, and exactly 256 when it is 0. A full-length frame is one whose strobes are M system clocks apart.
- R2: The clock code sets the frame length M. Code 0 gives 1620, code 1 gives 2430, code 2 gives 3240, code 3 gives 4860, code 4 gives 6480 and code 5 gives 9720. Codes 6 and 7 behave exactly like code 0.
- R3: Let k be the index of a system-clock cycle within the frame. Cycle k = 0 is the cycle after the edge that samples `frame_i` high. `bits_clk_o` is high at k = 0 whatever the earlier phase was. A strobe that arrives early restarts the pattern at k = 0.
- R4: A BITS period starts at cycle k exactly when (k·N mod M) < N, where N is 193 or 256. A period of L cycles runs until the next start, or until cycle M if no start follows. The output is high for its first floor(L/2) cycles and low for the rest.
- R5: The rate select and the clock code are sampled only in the cycle where `frame_i` is high. A change between strobes has no effect until the next strobe.
- R6: After reset and before the first frame strobe, `bits_clk_o` stays low.
- R7: `mode_reg_o` bit 2 always equals `rate_sel_i`. All other bits of `mode_reg_o` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rate_sel_i | input | 1 | Rate select: 1 gives 1.544 MHz, 0 gives 2.048 MHz |
| clk_sel_i | input | 3 | System-clock frequency code (0..5) |
| frame_i | input | 1 | 8 kHz frame-start strobe, one clock wide |
| bits_clk_o | output | 1 | Synthesized BITS clock |
| mode_reg_o | output | 8 | Control/mode word; bit 2 mirrors the rate select |

## Verification
The bench runs full frames at every defined clock code, with both rate values spread across them. It compares each cycle against a pattern that it builds from the modular start rule. This separates a wrong accumulator step or modulus from a wrong duty split within periods of unequal length. An undefined code is run and expected to reproduce code 0. A mid-frame flip of the rate pin shows that the pattern follows the captured setting while the mode bit follows the pin. A strobe that arrives early shows that the phase restarts rather than drifting into the next frame.

// File: rtl/bits_synth_pkg.sv
package bits_synth_pkg;
  localparam int unsigned CPF_UNIT     = 810;  // half of 12.96 MHz / 8 kHz
  localparam int unsigned T1_PER_FRAME = 193;
  localparam int unsigned E1_PER_FRAME = 256;
  localparam int unsigned CODE_W       = 3;
  localparam int unsigned CPF_MAX      = CPF_UNIT * 12;
  localparam int unsigned CPF_W        = $clog2(CPF_MAX + 1);
  localparam int unsigned N_W          = $clog2(E1_PER_FRAME + 1);
  localparam int unsigned LEN_W        = $clog2(CPF_MAX / T1_PER_FRAME + 2);

  typedef struct packed {
    logic [CPF_W-1:0] m;    // system clocks per frame
    logic [N_W-1:0]   n;    // BITS cycles per frame
    logic [LEN_W-1:0] lf;   // floor(m/n)
    logic [CPF_W-1:0] lfn;  // lf*n
  } frame_cfg_t;

  function automatic frame_cfg_t make_cfg(input int unsigned code, input int unsigned rate);
    int unsigned m;
    int unsigned n;
    int unsigned lf;
    frame_cfg_t  c;
    case (code)
      1:       m = CPF_UNIT * 3;
      2:       m = CPF_UNIT * 4;
      3:       m = CPF_UNIT * 6;
      4:       m = CPF_UNIT * 8;
      5:       m = CPF_UNIT * 12;
      default: m = CPF_UNIT * 2;
    endcase
    n     = (rate != 0) ? T1_PER_FRAME : E1_PER_FRAME;
    lf    = m / n;
    c.m   = CPF_W'(m);
    c.n   = N_W'(n);
    c.lf  = LEN_W'(lf);
    c.lfn = CPF_W'(lf * n);
    return c;
  endfunction
endpackage

// File: rtl/bits_phase_acc.sv
module bits_phase_acc
  import bits_synth_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  frame_cfg_t       cfg_i,
  output logic             start_o,
  output logic [LEN_W-1:0] len_o
);
  logic [CPF_W-1:0] acc_q, acc_d;
  logic [CPF_W:0]   sum;
  logic [CPF_W:0]   reach;

  always_comb begin
    sum = {1'b0, acc_q} + (CPF_W+1)'(cfg_i.n);
    if (restart_i) begin
      acc_d   = '0;
      start_o = 1'b1;
    end else if (sum >= {1'b0, cfg_i.m}) begin
      acc_d   = CPF_W'(sum - {1'b0, cfg_i.m});
      start_o = 1'b1;
    end else begin
      acc_d   = sum[CPF_W-1:0];
      start_o = 1'b0;
    end
    // period is lf long if lf steps from this phase reach the modulus, else lf+1
    reach = {1'b0, acc_d} + {1'b0, cfg_i.lfn};
    len_o = (reach >= {1'b0, cfg_i.m}) ? cfg_i.lf : cfg_i.lf + LEN_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  p_acc_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i |-> (acc_q < cfg_i.m))
    else $error("accumulator outside modulus");
endmodule

// File: rtl/bits_pulse_shaper.sv
module bits_pulse_shaper
  import bits_synth_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             clk_o
);
  logic             armed_q;
  logic [LEN_W-1:0] hold_q;
  logic             out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      hold_q  <= '0;
      out_q   <= 1'b0;
    end else begin
      if (restart_i) armed_q <= 1'b1;
      if (!(armed_q || restart_i)) begin
        out_q  <= 1'b0;
        hold_q <= '0;
      end else if (start_i) begin
        out_q  <= 1'b1;
        hold_q <= (len_i >> 1) - LEN_W'(1);
      end else if (hold_q != '0) begin
        hold_q <= hold_q - LEN_W'(1);
      end else begin
        out_q  <= 1'b0;
      end
    end
  end

  assign clk_o = out_q;

  p_idle_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> !clk_o)
    else $error("output active before first frame");

  // shortest period is 6 clocks, so every high phase lasts at least 3
  p_min_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_o) |-> ($past(clk_o, 2) && $past(clk_o, 3)))
    else $error("high phase too short");
endmodule

// File: rtl/bits_clk_synth.sv
module bits_clk_synth
  import bits_synth_pkg::*;
#(
  parameter int unsigned MODE_W   = 8,
  parameter int unsigned RATE_BIT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rate_sel_i,
  input  logic [CODE_W-1:0] clk_sel_i,
  input  logic              frame_i,
  output logic              bits_clk_o,
  output logic [MODE_W-1:0] mode_reg_o
);
  localparam int unsigned CFG_ENTRIES = 2 ** (CODE_W + 1);

  frame_cfg_t       cfg_tab [CFG_ENTRIES];
  frame_cfg_t       cfg_q, cfg_cur;
  logic             start;
  logic [LEN_W-1:0] len;

  for (genvar g = 0; g < CFG_ENTRIES; g++) begin : g_cfg
    localparam frame_cfg_t ENTRY = make_cfg(g / 2, g % 2);
    assign cfg_tab[g] = ENTRY;
  end

  assign cfg_cur = frame_i ? cfg_tab[{clk_sel_i, rate_sel_i}] : cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cfg_q <= make_cfg(0, 0);
    else if (frame_i) cfg_q <= cfg_cur;
  end

  bits_phase_acc u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (frame_i),
    .cfg_i     (cfg_cur),
    .start_o   (start),
    .len_o     (len)
  );

  bits_pulse_shaper u_shape (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (frame_i),
    .start_i   (start),
    .len_i     (len),
    .clk_o     (bits_clk_o)
  );

  assign mode_reg_o = MODE_W'(rate_sel_i) << RATE_BIT;

  p_frame_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> bits_clk_o)
    else $error("no rising phase at frame start");

  p_cfg_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(cfg_q))
    else $error("settings changed between strobes");
endmodule

// File: tb/bits_clk_synth_tb_top.sv
module bits_clk_synth_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rate_sel_i = 1'b0;
  logic [2:0] clk_sel_i = 3'd0;
  logic       frame_i = 1'b0;
  logic       bits_clk_o;
  logic [7:0] mode_reg_o;

  int vecs = 0;
  int miss = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  bits_clk_synth dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rate_sel_i (rate_sel_i),
    .clk_sel_i  (clk_sel_i),
    .frame_i    (frame_i),
    .bits_clk_o (bits_clk_o),
    .mode_reg_o (mode_reg_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vecs++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int frame_len(input int code);
    case (code)
      1: return 2430;
      2: return 3240;
      3: return 4860;
      4: return 6480;
      5: return 9720;
      default: return 1620;
    endcase
  endfunction

  function automatic bit is_start(input int k, input int m, input int n);
    return ((k * n) % m) < n;
  endfunction

  function automatic bit exp_out(input int k, input int m, input int n);
    int s = k;
    int nx = k + 1;
    while (!is_start(s, m, n)) s--;
    while (nx < m && !is_start(nx, m, n)) nx++;
    return (k - s) < ((nx - s) / 2);
  endfunction

  // starts a frame at the current negedge and checks `len` cycles; ends on a negedge
  task automatic run_frame(input int code, input int rate, input int len, input int chg_at,
                           input string tag);
    int m = frame_len(code);
    int n = (rate != 0) ? 193 : 256;
    int bad = 0;
    int first_k = -1;
    int edges = 0;
    logic prev = 1'b0;
    clk_sel_i  = 3'(code);
    rate_sel_i = rate[0];
    frame_i    = 1'b1;
    @(negedge clk_i);
    frame_i = 1'b0;
    for (int k = 0; k < len; k++) begin
      if (k > 0) @(negedge clk_i);
      if (k == 0) check(bits_clk_o === 1'b1, "R3 high at frame edge", int'(bits_clk_o), 1);
      if (k == chg_at) begin
        rate_sel_i = ~rate_sel_i;
        #1;
        check(mode_reg_o === {5'b0, rate_sel_i, 2'b0}, "R7 mode bit follows pin",
              int'(mode_reg_o), int'({5'b0, rate_sel_i, 2'b0}));
      end
      if (bits_clk_o !== exp_out(k, m, n)) begin
        if (first_k < 0) first_k = k;
        bad++;
      end
      if (bits_clk_o && !prev) edges++;
      prev = bits_clk_o;
    end
    check(bad == 0, {tag, " R4 waveform mismatches (act=count, first k shown next)"}, bad, 0);
    if (bad != 0) $display("  first mismatching k = %0d", first_k);
    if (len == m) check(edges == n, {tag, " R1 edges per frame"}, edges, n);
  endtask

  task automatic t_reset;
    rate_sel_i = 1'b1;
    #1;
    check(mode_reg_o === 8'h04, "R7 mode word rate=1", int'(mode_reg_o), 4);
    rate_sel_i = 1'b0;
    #1;
    check(mode_reg_o === 8'h00, "R7 mode word rate=0", int'(mode_reg_o), 0);
    begin
      int highs = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk_i);
        if (bits_clk_o !== 1'b0) highs++;
      end
      check(highs == 0, "R6 low before first strobe", highs, 0);
    end
  endtask

  task automatic t_rates;
    run_frame(0, 0, frame_len(0), -1, "R2 code0 2.048");
    run_frame(0, 1, frame_len(0), -1, "R2 code0 1.544");
    run_frame(1, 1, frame_len(1), -1, "R2 code1 1.544");
    run_frame(2, 0, frame_len(2), -1, "R2 code2 2.048");
    run_frame(3, 1, frame_len(3), -1, "R2 code3 1.544");
    run_frame(4, 0, frame_len(4), -1, "R2 code4 2.048");
    run_frame(5, 1, frame_len(5), -1, "R2 code5 1.544");
  endtask

  task automatic t_bad_code;
    // codes 6 and 7 are modelled as code 0 (M = 1620)
    run_frame(6, 1, frame_len(0), -1, "R2 code6 as code0");
    run_frame(7, 0, frame_len(0), -1, "R2 code7 as code0");
  endtask

  task automatic t_mid_change;
    run_frame(0, 1, frame_len(0), 700, "R5 rate flip mid-frame");
    run_frame(0, 0, frame_len(0), -1, "R5 new rate at next frame");
  endtask

  task automatic t_early;
    run_frame(2, 0, 500, -1, "R3 short frame");
    run_frame(2, 0, frame_len(2), -1, "R3 restart after early strobe");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_rates();
    t_bad_code();
    t_mid_change();
    t_early();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      vecs++;
      miss++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end
endmodule